// File: doc/BRIEF.md
# Two-Level Maskable Interrupt Controller

This block gathers nine interrupt sources for a small microcontroller core and turns them into one interrupt request. Three sources are core sources: an external pin that triggers on a rising edge, a timer-0 overflow pulse and a port-change detector that watches four pins. The other six are peripheral sources: converter done, timer-1 overflow, timer period match, capture/compare, serial port and display. Each source has a sticky flag and its own enable bit. The peripheral sources pass through a shared group gate, and a global enable then gates every source.

Software reads and writes three 8-bit words through a simple register port: a control word that holds the global enable, the group enable and the core enables and flags; a peripheral flag word; and a peripheral enable word. The core sends an acknowledge strobe when it takes the interrupt, and this clears the global enable. It sends a return strobe when the service routine ends, and this sets the global enable again. The vector address output is fixed. A wake-up output reports any enabled pending source while ignoring the global enable, so a sleeping core can resume even with interrupts disabled.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After reset all three register words read 0x00, and irq_o and wake_o are low.
- R2: A pulse on tmr0_ovf_i or on any bit of periph_evt_i sets the matching flag on the next clock edge, whatever the state of every enable bit. Peripheral word bit positions are 0 converter, 1 timer-1, 2 period match, 3 capture/compare, 4 serial, 5 display.
- R3: When an event pulse and a register write that clears the same flag arrive in the same cycle, the flag ends up set. Written flag bits that have no event take the written value.
- R4: Control word (address 0) layout: bit 7 global enable, bit 6 peripheral group enable, bits 5/4/3 enables of external pin, timer-0 and port change, bits 2/1/0 their flags. Address 1 is the peripheral flag word, address 2 the peripheral enable word, and address 3 reads 0x00. irq_o is high exactly when the global enable is set and a core source or the gated peripheral group is pending.
- R5: A peripheral source whose flag and enable are both set does not drive irq_o or wake_o while the group enable is clear.
- R6: wake_o is high exactly when a source is pending through its own enable and the group gate, whether or not the global enable is set.
- R7: irq_ack_i clears the global enable on the next edge and leaves every flag unchanged. vector_o always reads 0x0004.
- R8: irq_ret_i sets the global enable on the next edge. If it arrives together with irq_ack_i, the acknowledge wins.
- R9: A rising edge on ext_pin_i sets the external flag on the third clock edge after the pin changes (two synchronizer stages plus the flag register). A falling edge sets nothing.
- R10: A change on any bit of chg_pins_i, in either direction, sets the port-change flag with the same three-edge latency. Pins held steady set nothing.
- R11: Hardware never clears a flag. After acknowledge and return, a flag that software did not clear raises irq_o again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_pin_i | input | 1 | Asynchronous external interrupt pin |
| chg_pins_i | input | 4 | Asynchronous pins watched for change |
| tmr0_ovf_i | input | 1 | Timer-0 overflow pulse |
| periph_evt_i | input | 6 | Peripheral event pulses |
| reg_addr_i | input | 2 | Register word select |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, combinational on address |
| irq_ack_i | input | 1 | Core has taken the interrupt |
| irq_ret_i | input | 1 | Core returns from the service routine |
| irq_o | output | 1 | Interrupt request |
| vector_o | output | 16 | Fixed vector address |
| wake_o | output | 1 | Wake-up request, independent of global enable |

## Verification
On every cycle the assertions check how the global enable reacts to acknowledge and return strobes, that an event always leaves its flag set even during a clearing write, that a request never appears without the global enable or without wake-up, and that a closed group gate with no core source pending keeps wake-up low. Only the bench scenarios can show the full mapping from register contents to irq_o and wake_o across many enable combinations, the exact three-edge latency of the pin sources, the absence of a trigger on falling or steady pins, and a request coming back after return when its flag was left set.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;
   localparam int REG_W = 8;

   typedef enum logic [1:0] {
      ADDR_CTRL  = 2'd0,
      ADDR_PFLAG = 2'd1,
      ADDR_PEN   = 2'd2,
      ADDR_RSVD  = 2'd3
   } reg_addr_e;

   typedef enum logic {
      EDGE_RISE = 1'b0,
      EDGE_ANY  = 1'b1
   } edge_mode_e;

   // control word bit positions
   localparam int CTL_GIE    = 7;
   localparam int CTL_GRP    = 6;
   localparam int CTL_EN_HI  = 5;
   localparam int CTL_EN_LO  = 3;
   localparam int CTL_FLG_HI = 2;
   localparam int CTL_FLG_LO = 0;
   localparam int NUM_CORE   = 3;
endpackage

// File: rtl/irq_sync_edge.sv
module irq_sync_edge #(
   parameter int                      W      = 1,
   parameter int                      STAGES = 2,
   parameter irq_nest_pkg::edge_mode_e MODE  = irq_nest_pkg::EDGE_RISE
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] async_i,
   output logic         evt_o
);
   localparam int LAST = STAGES - 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("irq_sync_edge: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("irq_sync_edge: W must be at least 1");
   end

   logic [W-1:0] chain_q [STAGES];
   logic [W-1:0] last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) chain_q[i] <= '0;
         last_q <= '0;
      end else begin
         chain_q[0] <= async_i;
         for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
         last_q <= chain_q[LAST];
      end
   end

   if (MODE == irq_nest_pkg::EDGE_RISE) begin : g_rise
      assign evt_o = |(chain_q[LAST] & ~last_q);
   end else begin : g_any
      assign evt_o = |(chain_q[LAST] ^ last_q);
   end
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
   parameter int W = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_i,
   input  logic         wr_i,
   input  logic [W-1:0] wdata_i,
   output logic [W-1:0] flag_o
);
   if (W < 1) begin : g_bad_width
      $error("irq_flag_bank: W must be at least 1");
   end

   // events override software writes bit by bit
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_o <= '0;
      else        flag_o <= set_i | (wr_i ? wdata_i : flag_o);
   end
endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl #(
   parameter int          NUM_PERIPH  = 6,
   parameter int          CHG_W       = 4,
   parameter int          SYNC_STAGES = 2,
   parameter int          VEC_W       = 16,
   parameter logic [15:0] VEC_ADDR    = 16'h0004
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  ext_pin_i,
   input  logic [CHG_W-1:0]      chg_pins_i,
   input  logic                  tmr0_ovf_i,
   input  logic [NUM_PERIPH-1:0] periph_evt_i,
   input  logic [1:0]            reg_addr_i,
   input  logic                  reg_wr_i,
   input  logic [7:0]            reg_wdata_i,
   output logic [7:0]            reg_rdata_o,
   input  logic                  irq_ack_i,
   input  logic                  irq_ret_i,
   output logic                  irq_o,
   output logic [VEC_W-1:0]      vector_o,
   output logic                  wake_o
);
   import irq_nest_pkg::*;

   if (NUM_PERIPH < 1 || NUM_PERIPH > REG_W) begin : g_bad_periph
      $error("irq_nest_ctrl: NUM_PERIPH must be 1..8");
   end
   if (VEC_W < 1 || VEC_W > 16) begin : g_bad_vec
      $error("irq_nest_ctrl: VEC_W must be 1..16");
   end

   localparam int CORE_EXT = 2;
   localparam int CORE_TMR = 1;
   localparam int CORE_CHG = 0;

   logic                  ext_evt, chg_evt;
   logic                  gie_q, grp_en_q;
   logic [NUM_CORE-1:0]   core_en_q;
   logic [NUM_CORE-1:0]   core_flag;
   logic [NUM_CORE-1:0]   core_set;
   logic [NUM_PERIPH-1:0] pen_q;
   logic [NUM_PERIPH-1:0] pflag;
   logic                  wr_ctrl, wr_pflag, wr_pen;
   logic                  core_pend, periph_pend, any_pend;
   logic [REG_W-1:0]      ctrl_word;

   assign wr_ctrl  = reg_wr_i && (reg_addr_e'(reg_addr_i) == ADDR_CTRL);
   assign wr_pflag = reg_wr_i && (reg_addr_e'(reg_addr_i) == ADDR_PFLAG);
   assign wr_pen   = reg_wr_i && (reg_addr_e'(reg_addr_i) == ADDR_PEN);

   irq_sync_edge #(.W(1), .STAGES(SYNC_STAGES), .MODE(EDGE_RISE)) u_ext_sync (
      .clk(clk), .rst_n(rst_n), .async_i(ext_pin_i), .evt_o(ext_evt));

   irq_sync_edge #(.W(CHG_W), .STAGES(SYNC_STAGES), .MODE(EDGE_ANY)) u_chg_sync (
      .clk(clk), .rst_n(rst_n), .async_i(chg_pins_i), .evt_o(chg_evt));

   always_comb begin
      core_set           = '0;
      core_set[CORE_EXT] = ext_evt;
      core_set[CORE_TMR] = tmr0_ovf_i;
      core_set[CORE_CHG] = chg_evt;
   end

   irq_flag_bank #(.W(NUM_CORE)) u_core_flags (
      .clk(clk), .rst_n(rst_n), .set_i(core_set), .wr_i(wr_ctrl),
      .wdata_i(reg_wdata_i[CTL_FLG_HI:CTL_FLG_LO]), .flag_o(core_flag));

   irq_flag_bank #(.W(NUM_PERIPH)) u_periph_flags (
      .clk(clk), .rst_n(rst_n), .set_i(periph_evt_i), .wr_i(wr_pflag),
      .wdata_i(reg_wdata_i[NUM_PERIPH-1:0]), .flag_o(pflag));

   // enables; acknowledge outranks return, both outrank a write
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gie_q     <= 1'b0;
         grp_en_q  <= 1'b0;
         core_en_q <= '0;
         pen_q     <= '0;
      end else begin
         if (wr_ctrl) begin
            gie_q     <= reg_wdata_i[CTL_GIE];
            grp_en_q  <= reg_wdata_i[CTL_GRP];
            core_en_q <= reg_wdata_i[CTL_EN_HI:CTL_EN_LO];
         end
         if (wr_pen) pen_q <= reg_wdata_i[NUM_PERIPH-1:0];
         if (irq_ret_i) gie_q <= 1'b1;
         if (irq_ack_i) gie_q <= 1'b0;
      end
   end

   assign core_pend   = |(core_flag & core_en_q);
   assign periph_pend = grp_en_q & (|(pflag & pen_q));
   assign any_pend    = core_pend | periph_pend;
   assign wake_o      = any_pend;
   assign irq_o       = any_pend & gie_q;
   assign vector_o    = VEC_ADDR[VEC_W-1:0];

   always_comb begin
      ctrl_word                        = '0;
      ctrl_word[CTL_GIE]               = gie_q;
      ctrl_word[CTL_GRP]               = grp_en_q;
      ctrl_word[CTL_EN_HI:CTL_EN_LO]   = core_en_q;
      ctrl_word[CTL_FLG_HI:CTL_FLG_LO] = core_flag;
   end

   always_comb begin
      case (reg_addr_e'(reg_addr_i))
         ADDR_CTRL:  reg_rdata_o = ctrl_word;
         ADDR_PFLAG: reg_rdata_o = REG_W'(pflag);
         ADDR_PEN:   reg_rdata_o = REG_W'(pen_q);
         default:    reg_rdata_o = '0;
      endcase
   end
endmodule

// File: rtl/irq_nest_ctrl_chk.sv
module irq_nest_ctrl_chk #(
   parameter int          NUM_PERIPH = 6,
   parameter int          VEC_W      = 16,
   parameter logic [15:0] VEC_ADDR   = 16'h0004
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  irq_ack_i,
   input logic                  irq_ret_i,
   input logic                  tmr0_ovf_i,
   input logic [NUM_PERIPH-1:0] periph_evt_i,
   input logic                  irq_o,
   input logic                  wake_o,
   input logic [VEC_W-1:0]      vector_o,
   input logic                  gie,
   input logic                  grp_en,
   input logic [2:0]            core_en,
   input logic [2:0]            core_flag,
   input logic [NUM_PERIPH-1:0] pflag
);
   assert_ack_clears_gie_R7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ack_i |=> !gie);

   assert_ret_sets_gie_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ret_i && !irq_ack_i) |=> gie);

   assert_irq_needs_gie_R4: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> gie);

   assert_wake_covers_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> wake_o);

   assert_group_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!grp_en && ((core_en & core_flag) == 3'b000)) |-> !wake_o);

   assert_periph_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (|periph_evt_i) |=> ((pflag & $past(periph_evt_i)) == $past(periph_evt_i)));

   assert_event_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
      tmr0_ovf_i |=> core_flag[1]);

   assert_vector_R7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (vector_o == VEC_ADDR[VEC_W-1:0]));
endmodule

bind irq_nest_ctrl irq_nest_ctrl_chk #(
   .NUM_PERIPH(NUM_PERIPH), .VEC_W(VEC_W), .VEC_ADDR(VEC_ADDR)
) chk_i (
   .clk(clk), .rst_n(rst_n), .irq_ack_i(irq_ack_i), .irq_ret_i(irq_ret_i),
   .tmr0_ovf_i(tmr0_ovf_i), .periph_evt_i(periph_evt_i), .irq_o(irq_o),
   .wake_o(wake_o), .vector_o(vector_o), .gie(gie_q), .grp_en(grp_en_q),
   .core_en(core_en_q), .core_flag(core_flag), .pflag(pflag)
);

// File: tb/irq_nest_ctrl_tb.sv
`timescale 1ns/1ps
module irq_nest_ctrl_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ext_pin_i = 1'b0;
   logic [3:0] chg_pins_i = '0;
   logic       tmr0_ovf_i = 1'b0;
   logic [5:0] periph_evt_i = '0;
   logic [1:0] reg_addr_i = '0;
   logic       reg_wr_i = 1'b0;
   logic [7:0] reg_wdata_i = '0;
   logic [7:0] reg_rdata_o;
   logic       irq_ack_i = 1'b0;
   logic       irq_ret_i = 1'b0;
   logic       irq_o;
   logic [15:0] vector_o;
   logic       wake_o;

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   always #10 clk = ~clk;

   irq_nest_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .ext_pin_i(ext_pin_i), .chg_pins_i(chg_pins_i),
      .tmr0_ovf_i(tmr0_ovf_i), .periph_evt_i(periph_evt_i),
      .reg_addr_i(reg_addr_i), .reg_wr_i(reg_wr_i), .reg_wdata_i(reg_wdata_i),
      .reg_rdata_o(reg_rdata_o), .irq_ack_i(irq_ack_i), .irq_ret_i(irq_ret_i),
      .irq_o(irq_o), .vector_o(vector_o), .wake_o(wake_o));

   always @(posedge clk) begin
      cyc++;
      if (cyc == 100000) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_addr_i = a; reg_wdata_i = d; reg_wr_i = 1'b1;
      @(negedge clk);
      reg_wr_i = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      reg_addr_i = a;
      #1;
      d = reg_rdata_o;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // {ctrl, pflag, pen, irq, wake}
   localparam logic [25:0] VECS [10] = '{
      {8'h00, 8'h00, 8'h00, 1'b0, 1'b0},
      {8'h24, 8'h00, 8'h00, 1'b0, 1'b1},
      {8'hA4, 8'h00, 8'h00, 1'b1, 1'b1},
      {8'h84, 8'h00, 8'h00, 1'b0, 1'b0},
      {8'hC0, 8'h01, 8'h01, 1'b1, 1'b1},
      {8'h80, 8'h01, 8'h01, 1'b0, 1'b0},
      {8'h40, 8'h20, 8'h20, 1'b0, 1'b1},
      {8'hC0, 8'h20, 8'h10, 1'b0, 1'b0},
      {8'h92, 8'h00, 8'h00, 1'b1, 1'b1},
      {8'h89, 8'h00, 8'h00, 1'b1, 1'b1}
   };

   initial begin
      logic [7:0] d;
      repeat (3) @(negedge clk);
      // R1 reset state
      rd(2'd0, d); chk("R1 ctrl", 16'(d), 16'h00);
      rd(2'd1, d); chk("R1 pflag", 16'(d), 16'h00);
      rd(2'd2, d); chk("R1 pen", 16'(d), 16'h00);
      chk("R1 irq", 16'(irq_o), 16'h0);
      chk("R1 wake", 16'(wake_o), 16'h0);
      rst_n = 1'b1;
      idle(2);

      // R4 R5 R6 gating table
      for (int v = 0; v < 10; v++) begin
         wr(2'd1, VECS[v][17:10]);
         wr(2'd2, VECS[v][9:2]);
         wr(2'd0, VECS[v][25:18]);
         chk($sformatf("R4 irq vec%0d", v), 16'(irq_o), 16'(VECS[v][1]));
         chk($sformatf("R6 wake vec%0d", v), 16'(wake_o), 16'(VECS[v][0]));
      end

      // R4 reserved address
      rd(2'd3, d); chk("R4 rsvd", 16'(d), 16'h00);

      // R2 flags set with every enable clear
      wr(2'd0, 8'h00); wr(2'd1, 8'h00); wr(2'd2, 8'h00);
      @(negedge clk); periph_evt_i = 6'b101010; tmr0_ovf_i = 1'b1;
      @(negedge clk); periph_evt_i = '0; tmr0_ovf_i = 1'b0;
      rd(2'd1, d); chk("R2 pflag", 16'(d), 16'h2A);
      rd(2'd0, d); chk("R2 tmr0 flag", 16'(d), 16'h02);
      chk("R2 no wake", 16'(wake_o), 16'h0);

      // R3 event wins against clearing write
      @(negedge clk);
      reg_addr_i = 2'd1; reg_wdata_i = 8'h00; reg_wr_i = 1'b1; periph_evt_i = 6'b000100;
      @(negedge clk);
      reg_wr_i = 1'b0; periph_evt_i = '0;
      rd(2'd1, d); chk("R3 event wins", 16'(d), 16'h04);

      // R7 acknowledge
      wr(2'd1, 8'h00);
      wr(2'd0, 8'hA4);
      chk("R7 irq before ack", 16'(irq_o), 16'h1);
      chk("R7 vector", vector_o, 16'h0004);
      @(negedge clk); irq_ack_i = 1'b1;
      @(negedge clk); irq_ack_i = 1'b0;
      chk("R7 irq after ack", 16'(irq_o), 16'h0);
      rd(2'd0, d); chk("R7 flag kept", 16'(d), 16'h24);

      // R8 R11 return re-raises since flag stays set
      @(negedge clk); irq_ret_i = 1'b1;
      @(negedge clk); irq_ret_i = 1'b0;
      chk("R11 irq again", 16'(irq_o), 16'h1);
      rd(2'd0, d); chk("R8 gie set", 16'(d), 16'hA4);
      @(negedge clk); irq_ack_i = 1'b1; irq_ret_i = 1'b1;
      @(negedge clk); irq_ack_i = 1'b0; irq_ret_i = 1'b0;
      rd(2'd0, d); chk("R8 ack wins", 16'(d), 16'h24);

      // R9 external pin latency
      wr(2'd0, 8'hA0);
      @(negedge clk); ext_pin_i = 1'b1;
      @(negedge clk); chk("R9 edge1", 16'(irq_o), 16'h0);
      @(negedge clk); chk("R9 edge2", 16'(irq_o), 16'h0);
      @(negedge clk); chk("R9 edge3", 16'(irq_o), 16'h1);
      wr(2'd0, 8'hA0);
      @(negedge clk); ext_pin_i = 1'b0;
      idle(5);
      rd(2'd0, d); chk("R9 falling ignored", 16'(d), 16'hA0);

      // R10 port change latency, both directions
      wr(2'd0, 8'h88);
      @(negedge clk); chg_pins_i = 4'b0100;
      @(negedge clk); chk("R10 edge1", 16'(irq_o), 16'h0);
      @(negedge clk); chk("R10 edge2", 16'(irq_o), 16'h0);
      @(negedge clk); chk("R10 edge3", 16'(irq_o), 16'h1);
      wr(2'd0, 8'h88);
      idle(5);
      rd(2'd0, d); chk("R10 steady ignored", 16'(d), 16'h88);
      @(negedge clk); chg_pins_i = 4'b0000;
      idle(4);
      rd(2'd0, d); chk("R10 change back", 16'(d), 16'h89);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule